// File: doc/BRIEF.md
# Floating-Point Status Register Update Unit

This block holds a 64-bit floating-point status register and changes it in response to events from a floating-point pipeline. An arithmetic event supplies five IEEE exception flags. The unit loads them as the current exceptions. It then either raises a trap, when an enabled exception is present, or folds the flags into the accrued exception field.

A compare event supplies a two-bit relation for one of four condition-code pairs. The unit rewrites that pair. An unordered result also updates the invalid-operation state, or raises a trap. Software can overwrite the whole register through a write port.

One event is taken per cycle. The new register value and the trap pulse appear on the cycle after the strobe.

Top module: `fsr_update`

## Requirements
- R1: After reset, `fsr_o` is all zeros and `trap_o` is low.
- R2: An arithmetic event (`flag_valid`) replaces the current-exception field `fsr_o[4:0]` with `flags`. The flag bits are: inexact bit 0, divide-by-zero bit 1, underflow bit 2, overflow bit 3, invalid bit 4.
- R3: An arithmetic event traps when `flags` AND the enable field `fsr_o[27:23]` is non-zero. The enable bit for each flag is the flag's bit position plus 23.
- R4: A trapping event writes the trap-type field `fsr_o[16:14]` to code 1 and pulses `trap_o` high for exactly one cycle. A trapping arithmetic event leaves the accrued field unchanged.
- R5: A non-trapping arithmetic event ORs `flags` into the accrued field `fsr_o[9:5]` and does not change the trap-type field.
- R6: A compare event (`cmp_valid`) rewrites only the pair selected by `cmp_sel`. Selection 0 puts the pair at bits 11:10, 1 at 33:32, 2 at 35:34 and 3 at 37:36. All other bits keep their values unless R7 or R8 applies.
- R7: `cmp_res` encodings: 0 is equal and gives pair 00. 1 is less and gives pair 01 (only the low bit set). 2 is greater and gives pair 10 (only the high bit set). 3 is unordered and gives pair 11.
- R8: An unordered compare traps when the invalid-enable bit 27 is set or `cmp_signal` is high. It then sets current invalid bit 4 and follows R4, with the accrued field unchanged.
- R9: An unordered compare that does not trap sets accrued invalid bit 9. The current-exception field and the trap-type field stay unchanged.
- R10: `wr_en` loads `wr_data` into the whole register. When several strobes are high in one cycle, only one event is accepted, in priority order `wr_en`, then `flag_valid`, then `cmp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Software write strobe |
| wr_data | input | 64 | Value to load on a write |
| flag_valid | input | 1 | Arithmetic event strobe |
| flags | input | 5 | IEEE exception flags of the arithmetic event |
| cmp_valid | input | 1 | Compare event strobe |
| cmp_res | input | 2 | Compare relation: 0 equal, 1 less, 2 greater, 3 unordered |
| cmp_sel | input | 2 | Condition-code pair select |
| cmp_signal | input | 1 | Signaling compare: an unordered result always traps |
| fsr_o | output | 64 | Status register value |
| trap_o | output | 1 | One-cycle trap request |

## Verification
Some assertions relate an output to the event strobe of the previous cycle. For those, the assertions assume that the strobes and their payloads are valid on the clock edge and held low during reset. The bench drives every input on the falling edge and keeps all strobes low while `rst_n` is asserted. It raises more than one strobe in a cycle only in the priority scenario. The properties that check the arithmetic and compare paths are conditioned on no higher-priority strobe being present, so that scenario stays within them.

// File: rtl/fsr_pkg.sv
package fsr_pkg;
    localparam int FSR_W    = 64;
    localparam int FLAG_W   = 5;
    localparam int CUR_LSB  = 0;
    localparam int ACC_LSB  = CUR_LSB + 5;
    localparam int EN_LSB   = CUR_LSB + 23;
    localparam int TT_LSB   = 14;
    localparam int TT_W     = 3;
    localparam int CC_BASE  = 10;
    localparam int CC_NUM   = 4;
    localparam int INV_BIT  = 4;
    localparam logic [TT_W-1:0] TT_IEEE = 3'd1;

    typedef enum logic [1:0] {
        REL_EQ = 2'd0,
        REL_LT = 2'd1,
        REL_GT = 2'd2,
        REL_UN = 2'd3
    } rel_e;

    typedef struct packed {
        logic [FSR_W-1:0] fsr;
        logic             trap;
    } fsr_state_t;

    function automatic int cc_pos(input int idx);
        return (idx == 0) ? CC_BASE : CC_BASE + 20 + 2 * idx;
    endfunction
endpackage

// File: rtl/fsr_arith_upd.sv
module fsr_arith_upd
    import fsr_pkg::*;
(
    input  logic [FSR_W-1:0]  cur_reg,
    input  logic [FLAG_W-1:0] flags,
    output logic [FSR_W-1:0]  nxt_reg,
    output logic              nxt_trap
);
    logic [FLAG_W-1:0] enabled_hits;

    always_comb begin
        enabled_hits = flags & cur_reg[EN_LSB +: FLAG_W];
        nxt_reg      = cur_reg;
        nxt_reg[CUR_LSB +: FLAG_W] = flags;
        nxt_trap     = |enabled_hits;
        if (nxt_trap) begin
            nxt_reg[TT_LSB +: TT_W] = TT_IEEE;
        end else begin
            nxt_reg[ACC_LSB +: FLAG_W] = cur_reg[ACC_LSB +: FLAG_W] | flags;
        end
    end
endmodule

// File: rtl/fsr_cmp_upd.sv
module fsr_cmp_upd
    import fsr_pkg::*;
(
    input  logic [FSR_W-1:0] cur_reg,
    input  logic [1:0]       sel,
    input  logic [1:0]       rel,
    input  logic             signaling,
    output logic [FSR_W-1:0] nxt_reg,
    output logic             nxt_trap
);
    logic [FSR_W-1:0] lo_mask [CC_NUM];
    logic [FSR_W-1:0] hi_mask [CC_NUM];
    logic [FSR_W-1:0] lo_sel;
    logic [FSR_W-1:0] hi_sel;

    for (genvar i = 0; i < CC_NUM; i++) begin : g_pair
        assign lo_mask[i] = FSR_W'(1) << cc_pos(i);
        assign hi_mask[i] = FSR_W'(1) << (cc_pos(i) + 1);
    end

    always_comb begin
        lo_sel   = lo_mask[sel];
        hi_sel   = hi_mask[sel];
        nxt_reg  = cur_reg & ~(lo_sel | hi_sel);
        nxt_trap = 1'b0;
        unique case (rel_e'(rel))
            REL_LT: nxt_reg = nxt_reg | lo_sel;
            REL_GT: nxt_reg = nxt_reg | hi_sel;
            REL_UN: begin
                nxt_reg = nxt_reg | lo_sel | hi_sel;
                if (cur_reg[EN_LSB + INV_BIT] || signaling) begin
                    nxt_trap = 1'b1;
                    nxt_reg[CUR_LSB + INV_BIT] = 1'b1;
                    nxt_reg[TT_LSB +: TT_W]    = TT_IEEE;
                end else begin
                    nxt_reg[ACC_LSB + INV_BIT] = 1'b1;
                end
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/fsr_update.sv
module fsr_update
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FSR_W-1:0]  wr_data,
    input  logic              flag_valid,
    input  logic [FLAG_W-1:0] flags,
    input  logic              cmp_valid,
    input  logic [1:0]        cmp_res,
    input  logic [1:0]        cmp_sel,
    input  logic              cmp_signal,
    output logic [FSR_W-1:0]  fsr_o,
    output logic              trap_o
);
    fsr_state_t       st_d, st_q;
    logic [FSR_W-1:0] ar_reg, cp_reg;
    logic             ar_trap, cp_trap;

    fsr_arith_upd u_arith (
        .cur_reg (st_q.fsr),
        .flags   (flags),
        .nxt_reg (ar_reg),
        .nxt_trap(ar_trap)
    );

    fsr_cmp_upd u_cmp (
        .cur_reg  (st_q.fsr),
        .sel      (cmp_sel),
        .rel      (cmp_res),
        .signaling(cmp_signal),
        .nxt_reg  (cp_reg),
        .nxt_trap (cp_trap)
    );

    always_comb begin
        st_d      = st_q;
        st_d.trap = 1'b0;
        if (wr_en) begin
            st_d.fsr = wr_data;
        end else if (flag_valid) begin
            st_d.fsr  = ar_reg;
            st_d.trap = ar_trap;
        end else if (cmp_valid) begin
            st_d.fsr  = cp_reg;
            st_d.trap = cp_trap;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign fsr_o  = st_q.fsr;
    assign trap_o = st_q.trap;

    // R2: an accepted arithmetic event leaves its flags in the current field
    p_cur_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(flag_valid) && !$past(wr_en))
        |-> fsr_o[CUR_LSB +: FLAG_W] == $past(flags));

    // R4: a trap always carries the IEEE trap type
    p_trap_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> fsr_o[TT_LSB +: TT_W] == TT_IEEE);

    // R4: a trap follows an event strobe and lasts one cycle
    p_trap_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_o |-> ($past(rst_n) && ($past(flag_valid) || $past(cmp_valid))
                    && !$past(wr_en) && !$past(trap_o)));

    // R5: the accrued field never loses bits except through a write
    p_acc_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(wr_en))
        |-> ((fsr_o[ACC_LSB +: FLAG_W] & $past(fsr_o[ACC_LSB +: FLAG_W]))
             == $past(fsr_o[ACC_LSB +: FLAG_W])));

    // R6: a compare never touches the enable field
    p_cmp_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(cmp_valid) && !$past(wr_en) && !$past(flag_valid))
        |-> $stable(fsr_o[EN_LSB +: FLAG_W]));

    // R10: a write is taken verbatim
    p_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(wr_en)) |-> (fsr_o == $past(wr_data) && !trap_o));
endmodule

// File: tb/tb_fsr_update.sv
`timescale 1ns/1ps
module tb_fsr_update;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        flag_valid = 1'b0;
    logic [4:0]  flags = '0;
    logic        cmp_valid = 1'b0;
    logic [1:0]  cmp_res = '0;
    logic [1:0]  cmp_sel = '0;
    logic        cmp_signal = 1'b0;
    logic [63:0] fsr_o;
    logic        trap_o;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    localparam logic [63:0] TT_ONE = 64'd1 << 14;

    always #2 clk = ~clk;

    fsr_update dut (.*);

    function automatic logic [63:0] en_bits(input logic [4:0] e);
        return {36'd0, e, 23'd0};
    endfunction
    function automatic logic [63:0] acc_bits(input logic [4:0] a);
        return {54'd0, a, 5'd0};
    endfunction
    function automatic int pair_lsb(input int s);
        return (s == 0) ? 10 : 30 + 2 * s;
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [63:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic do_arith(input logic [4:0] f);
        @(negedge clk); flag_valid = 1'b1; flags = f;
        @(negedge clk); flag_valid = 1'b0;
    endtask

    task automatic do_cmp(input logic [1:0] s, input logic [1:0] r, input logic sg);
        @(negedge clk); cmp_valid = 1'b1; cmp_sel = s; cmp_res = r; cmp_signal = sg;
        @(negedge clk); cmp_valid = 1'b0; cmp_signal = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 reg", fsr_o, 64'd0);
        check("R1 trap", {63'd0, trap_o}, 64'd0);
    endtask

    task automatic t_write();
        do_write(64'hA5A5_0000_1234_5678);
        check("R10 write", fsr_o, 64'hA5A5_0000_1234_5678);
    endtask

    task automatic t_arith_accrue();
        do_write(64'd0);
        do_arith(5'b00011);
        check("R5 accrue", fsr_o, 64'h3 | acc_bits(5'b00011));
        check("R5 no trap", {63'd0, trap_o}, 64'd0);
        do_write(64'h1F | acc_bits(5'b10000));
        do_arith(5'b00100);
        check("R2 overwrite", fsr_o, 64'h4 | acc_bits(5'b10100));
    endtask

    task automatic t_arith_trap();
        do_write(en_bits(5'b01000));
        do_arith(5'b00001);
        check("R3 masked", fsr_o, en_bits(5'b01000) | 64'h1 | acc_bits(5'b00001));
        check("R3 masked trap", {63'd0, trap_o}, 64'd0);
        do_write(en_bits(5'b01000));
        do_arith(5'b01001);
        check("R3 trap", {63'd0, trap_o}, 64'd1);
        check("R4 fields", fsr_o, en_bits(5'b01000) | 64'h9 | TT_ONE);
        @(negedge clk);
        check("R4 single pulse", {63'd0, trap_o}, 64'd0);
    endtask

    task automatic t_cmp_codes();
        for (int s = 0; s < 4; s++) begin
            do_write(64'd0);
            do_cmp(s[1:0], 2'd1, 1'b0);
            check($sformatf("R6 less sel%0d", s), fsr_o, 64'd1 << pair_lsb(s));
            do_cmp(s[1:0], 2'd2, 1'b0);
            check($sformatf("R7 greater sel%0d", s), fsr_o, 64'd2 << pair_lsb(s));
        end
        do_write((64'd3 << 10) | (64'd3 << 34));
        do_cmp(2'd2, 2'd0, 1'b0);
        check("R7 equal clears", fsr_o, 64'd3 << 10);
    endtask

    task automatic t_cmp_unordered();
        do_write(64'h2);
        do_cmp(2'd1, 2'd3, 1'b0);
        check("R9 quiet", fsr_o, 64'h2 | (64'd3 << 32) | acc_bits(5'b10000));
        check("R9 no trap", {63'd0, trap_o}, 64'd0);
        do_write(64'h2);
        do_cmp(2'd0, 2'd3, 1'b1);
        check("R8 signaling trap", {63'd0, trap_o}, 64'd1);
        check("R8 signaling fields", fsr_o, 64'h12 | (64'd3 << 10) | TT_ONE);
        do_write(en_bits(5'b10000));
        do_cmp(2'd3, 2'd3, 1'b0);
        check("R8 enable trap", {63'd0, trap_o}, 64'd1);
        check("R8 enable fields", fsr_o,
              en_bits(5'b10000) | 64'h10 | (64'd3 << 36) | TT_ONE);
    endtask

    task automatic t_priority();
        do_write(64'd0);
        @(negedge clk);
        wr_en = 1'b1; wr_data = 64'h77; flag_valid = 1'b1; flags = 5'h1F; cmp_valid = 1'b1;
        cmp_sel = 2'd0; cmp_res = 2'd3;
        @(negedge clk);
        wr_en = 1'b0; flag_valid = 1'b0; cmp_valid = 1'b0;
        check("R10 write wins", fsr_o, 64'h77);
        do_write(64'd0);
        @(negedge clk);
        flag_valid = 1'b1; flags = 5'b00010; cmp_valid = 1'b1; cmp_sel = 2'd0; cmp_res = 2'd2;
        @(negedge clk);
        flag_valid = 1'b0; cmp_valid = 1'b0;
        check("R10 arith beats compare", fsr_o, 64'h2 | acc_bits(5'b00010));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_arith_accrue();
        t_arith_trap();
        t_cmp_codes();
        t_cmp_unordered();
        t_priority();
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule